// File: doc/BRIEF.md
# Opcode-Counting ALU

This block is a small registered arithmetic and logic unit for a DSP datapath. Each cycle it takes two operands, `a_i` and `b_i`, and a 3-bit opcode `op_i`. The selected result is loaded into an output register and appears on `res_o` one clock later.

The available operations are:

- hold (NOP)
- pass-through of A
- add and subtract, both on one shared adder
- left shift by a small amount, built from multiplexers
- bitwise AND
- bitwise OR
- a usage counter

Result selection is done in two levels. A 6:1 multiplexer picks among the non-arithmetic results. A final 2:1 multiplexer then chooses between that value and the adder output, which keeps the adder on the short path.

The counter lets software measure how often one opcode is issued. The first issue of the counter opcode arms it and records the target opcode from `a_i[2:0]`. Every later cycle that carries exactly that opcode increments a tally. The next issue of the counter opcode returns the tally as the result and disarms the counter.

The counter is a two-state machine:

- State `TALLY_IDLE`: not counting. The transition "arm" moves it to `TALLY_ARMED` when opcode 111 is issued.
- State `TALLY_ARMED`: counting. The transition "report" moves it back to `TALLY_IDLE` on the next issue of 111.

Both transitions clear the tally.

Top module: `dsp_alu`

## Requirements
- R1: A synchronous active-high `rst` sets `res_o` to 0 and leaves the counter disarmed. The first counter issue after reset therefore arms it.
- R2: Opcode 000 (NOP) keeps `res_o` unchanged.
- R3: Opcode 001 loads A into the result.
- R4: Opcode 010 loads (A + B) mod 256 into the result.
- R5: Opcode 011 loads (A - B) mod 256 into the result, computed as A + ~B + 1.
- R6: Opcode 100 loads A shifted left by B[1:0] positions (0 to 3), with zeros filled in from the right and bits shifted out discarded.
- R7: Opcode 101 loads A AND B into the result.
- R8: Opcode 110 loads A OR B into the result.
- R9: Opcode 111 issued while disarmed loads 0 into the result, clears the tally, records A[2:0] as the target and arms the counter.
- R10: While armed, each cycle whose opcode equals the target in all three bits adds one to the tally. Non-matching opcodes leave the tally unchanged. Counted opcodes still perform their own function.
- R11: Opcode 111 issued while armed loads the tally into the result, clears the tally and disarms the counter.
- R12: The 8-bit tally saturates at 255 and does not wrap.
- R13: When the target is 111, the reporting issue takes priority over counting, so the report is 0.
- R14: Every result appears on `res_o` exactly one clock edge after its opcode is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 3 | Opcode |
| a_i | input | 8 | Operand A; bits 2:0 carry the counter target |
| b_i | input | 8 | Operand B; bits 1:0 carry the shift amount |
| res_o | output | 8 | Registered result |

## Verification
The hardest conditions to reach from the ports are the saturated tally and the case where the counter watches its own opcode. Both show up only at the reporting issue, after a long or unusual run of opcodes.

For saturation, the stimulus arms on the add opcode and then issues 300 back-to-back additions. This also checks that every sum stays correct while it is being counted.

Two further sequences cover the remaining corners:

- Arming on 111 itself, followed by a report, to exercise R13.
- Resetting in the middle of an armed count, followed by a counter issue that must arm again rather than report.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'b000,
        OP_PASS  = 3'b001,
        OP_ADD   = 3'b010,
        OP_SUB   = 3'b011,
        OP_SHL   = 3'b100,
        OP_AND   = 3'b101,
        OP_OR    = 3'b110,
        OP_TALLY = 3'b111
    } alu_op_e;

    typedef enum logic {
        TALLY_IDLE,
        TALLY_ARMED
    } tally_state_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          sub_i,
    output logic [DW-1:0] sum_o
);
    logic [DW-1:0] b_eff;

    // Subtract control inverts B and doubles as the carry-in.
    assign b_eff = b_i ^ {DW{sub_i}};
    assign sum_o = a_i + b_eff + {{(DW-1){1'b0}}, sub_i};

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int DW  = 8,
    parameter int SHW = 2
) (
    input  logic [DW-1:0]  a_i,
    input  logic [SHW-1:0] amt_i,
    output logic [DW-1:0]  shl_o
);
    localparam int NSTAGE = 1 << SHW;

    logic [DW-1:0] stage [NSTAGE];

    // One fixed shift per select value, then a plain mux.
    for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
        assign stage[k] = a_i << k;
    end

    assign shl_o = stage[amt_i];

endmodule

// File: rtl/op_tally.sv
module op_tally
    import alu_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  alu_op_e       op_i,
    input  logic [2:0]    tgt_i,
    output logic [DW-1:0] val_o,
    output logic [CW-1:0] cnt_o,
    output logic          armed_o
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    tally_state_e  state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [2:0]    tgt_q, tgt_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TALLY_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Tally and target registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tgt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            tgt_q <= tgt_d;
        end
    end

    // Transitions and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        tgt_d   = tgt_q;
        val_o   = '0;
        unique case (state_q)
            TALLY_IDLE: begin
                if (op_i == OP_TALLY) begin
                    // arm
                    state_d = TALLY_ARMED;
                    cnt_d   = '0;
                    tgt_d   = tgt_i;
                end
            end
            TALLY_ARMED: begin
                val_o = DW'(cnt_q);
                if (op_i == OP_TALLY) begin
                    // report
                    state_d = TALLY_IDLE;
                    cnt_d   = '0;
                end else if ((op_i == alu_op_e'(tgt_q)) && (cnt_q != CNT_MAX)) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
    end

    assign cnt_o   = cnt_q;
    assign armed_o = (state_q == TALLY_ARMED);

endmodule

// File: rtl/dsp_alu.sv
module dsp_alu
    import alu_pkg::*;
#(
    parameter int DW  = 8,
    parameter int CW  = 8,
    parameter int SHW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] res_o
);
    alu_op_e       op;
    logic [DW-1:0] res_q;
    logic [DW-1:0] sum;
    logic [DW-1:0] shl;
    logic [DW-1:0] tally_val;
    logic [CW-1:0] tally_cnt;
    logic          tally_armed;
    logic [DW-1:0] slow_sel;
    logic          is_arith;
    logic          is_sub;

    assign op       = alu_op_e'(op_i);
    assign is_arith = (op == OP_ADD) || (op == OP_SUB);
    assign is_sub   = (op == OP_SUB);

    alu_addsub #(.DW(DW)) u_addsub (
        .a_i   (a_i),
        .b_i   (b_i),
        .sub_i (is_sub),
        .sum_o (sum)
    );

    alu_shifter #(.DW(DW), .SHW(SHW)) u_shift (
        .a_i   (a_i),
        .amt_i (b_i[SHW-1:0]),
        .shl_o (shl)
    );

    op_tally #(.DW(DW), .CW(CW)) u_tally (
        .clk     (clk),
        .rst     (rst),
        .op_i    (op),
        .tgt_i   (a_i[2:0]),
        .val_o   (tally_val),
        .cnt_o   (tally_cnt),
        .armed_o (tally_armed)
    );

    // First level: six non-arithmetic sources
    always_comb begin
        unique case (op)
            OP_NOP:   slow_sel = res_q;
            OP_PASS:  slow_sel = a_i;
            OP_SHL:   slow_sel = shl;
            OP_AND:   slow_sel = a_i & b_i;
            OP_OR:    slow_sel = a_i | b_i;
            OP_TALLY: slow_sel = tally_val;
            default:  slow_sel = res_q;
        endcase
    end

    // Second level: adder result kept on the short path
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= is_arith ? sum : slow_sel;
        end
    end

    assign res_o = res_q;

endmodule

// File: rtl/alu_chk.sv
module alu_chk #(
    parameter int DW = 8,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    op_i,
    input logic [DW-1:0] a_i,
    input logic [DW-1:0] b_i,
    input logic [DW-1:0] res_o,
    input logic [CW-1:0] cnt,
    input logic          armed
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic seen_edge;
    logic prev_rst;

    always_ff @(posedge clk) begin
        seen_edge <= 1'b1;
        prev_rst  <= rst;
    end

    // R1
    always_ff @(posedge clk) begin
        if (seen_edge === 1'b1 && prev_rst === 1'b1) begin
            reset_clear_chk: assert (res_o == '0 && !armed);
        end
    end

    // R2
    nop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'b000) |=> $stable(res_o));

    // R3
    pass_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'b001) |=> (res_o == $past(a_i)));

    // R4
    add_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'b010) |=> (res_o == DW'($past(a_i) + $past(b_i))));

    // R5
    sub_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'b011) |=> (res_o == DW'($past(a_i) - $past(b_i))));

    // R9
    arm_chk: assert property (@(posedge clk) disable iff (rst)
        (!armed && op_i == 3'b111) |=> (res_o == '0 && armed && cnt == '0));

    // R11
    report_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && op_i == 3'b111) |=> (res_o == DW'($past(cnt)) && !armed));

    // R10
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && op_i != 3'b111) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

    // R12
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && cnt == CNT_MAX && op_i != 3'b111) |=> (cnt == CNT_MAX));

endmodule

bind dsp_alu alu_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .op_i  (op_i),
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (res_o),
    .cnt   (tally_cnt),
    .armed (tally_armed)
);

// File: tb/test_dsp_alu.sv
`timescale 1ns/1ps
module test_dsp_alu;
    localparam real CLK_P = 8.0;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] op_i = 3'b000;
    logic [7:0] a_i = 8'h00;
    logic [7:0] b_i = 8'h00;
    logic [7:0] res_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Scoreboard queues
    logic [7:0] qv[$];
    string      qt[$];

    // Bench-side model state
    logic [7:0] m_res   = 8'h00;
    bit         m_armed = 1'b0;
    logic [2:0] m_tgt   = 3'b000;
    int         m_cnt   = 0;

    always #(CLK_P/2) clk = ~clk;

    dsp_alu i_dsp_alu (
        .clk   (clk),
        .rst   (rst),
        .op_i  (op_i),
        .a_i   (a_i),
        .b_i   (b_i),
        .res_o (res_o)
    );

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: res_o=%0h expected %0h", tag, got, exp);
        end
    endtask

    // Monitor: compare one result per clock, away from the rising edge
    always @(negedge clk) begin
        if (qv.size() > 0) begin
            check(res_o, qv.pop_front(), qt.pop_front());
        end
    end

    // Driver: apply one opcode, then push the expected result (R14: one edge later)
    task automatic issue(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b, input string tag);
        logic [7:0] e;
        @(negedge clk);
        op_i = op; a_i = a; b_i = b;
        @(posedge clk);
        e = m_res;
        case (op)
            3'b000: e = m_res;
            3'b001: e = a;
            3'b010: e = a + b;
            3'b011: e = a - b;
            3'b100: e = a << b[1:0];
            3'b101: e = a & b;
            3'b110: e = a | b;
            default: begin
                if (m_armed) begin
                    e = 8'(m_cnt); m_armed = 1'b0; m_cnt = 0;
                end else begin
                    e = 8'h00; m_armed = 1'b1; m_tgt = a[2:0]; m_cnt = 0;
                end
            end
        endcase
        if (op != 3'b111 && m_armed && op == m_tgt && m_cnt < 255) m_cnt++;
        m_res = e;
        qv.push_back(e);
        qt.push_back(tag);
    endtask

    task automatic drain();
        @(negedge clk);
        op_i = 3'b000;
        @(negedge clk);
    endtask

    task automatic do_reset();
        drain();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_res = 8'h00; m_armed = 1'b0; m_cnt = 0; m_tgt = 3'b000;
        // R1: result cleared by reset
        check(res_o, 8'h00, "R1");
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();

        // Basic functions
        issue(3'b001, 8'hA5, 8'h00, "R3");
        issue(3'b000, 8'h11, 8'h22, "R2");
        issue(3'b010, 8'h3C, 8'h14, "R4");
        issue(3'b010, 8'hF0, 8'h20, "R4");
        issue(3'b011, 8'h50, 8'h10, "R5");
        issue(3'b011, 8'h05, 8'h09, "R5");
        for (int s = 0; s < 4; s++) issue(3'b100, 8'hC3, 8'(s), "R6");
        issue(3'b101, 8'hCC, 8'hAA, "R7");
        issue(3'b110, 8'hCC, 8'hAA, "R8");
        issue(3'b000, 8'h00, 8'h00, "R2");

        // Arm on AND (101), mix counted and uncounted ops
        issue(3'b111, 8'hF5, 8'h00, "R9");
        issue(3'b101, 8'hFF, 8'h0F, "R10");
        issue(3'b110, 8'h01, 8'h02, "R10");
        issue(3'b101, 8'h3C, 8'hF0, "R10");
        issue(3'b100, 8'h05, 8'h01, "R10");
        issue(3'b101, 8'h81, 8'h81, "R10");
        issue(3'b111, 8'h00, 8'h00, "R11");
        // Re-arm starts from zero
        issue(3'b111, 8'h00, 8'h00, "R9");
        issue(3'b000, 8'h00, 8'h00, "R10");
        issue(3'b000, 8'h00, 8'h00, "R10");
        issue(3'b111, 8'h00, 8'h00, "R11");

        // Saturation on add
        issue(3'b111, 8'h02, 8'h00, "R9");
        for (int i = 0; i < 300; i++) issue(3'b010, 8'(i), 8'h07, "R12");
        issue(3'b111, 8'h00, 8'h00, "R12");

        // Target equal to the counter opcode
        issue(3'b111, 8'h07, 8'h00, "R13");
        issue(3'b010, 8'h01, 8'h01, "R13");
        issue(3'b111, 8'h00, 8'h00, "R13");

        // Reset while armed, then counter must arm again
        issue(3'b111, 8'h01, 8'h00, "R9");
        issue(3'b001, 8'h44, 8'h00, "R10");
        do_reset();
        issue(3'b111, 8'h01, 8'h00, "R1");
        issue(3'b001, 8'h66, 8'h00, "R3");
        issue(3'b111, 8'h00, 8'h00, "R11");

        drain();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule